// File: doc/BRIEF.md
# Dot-Clock PLL Reprogram and Lock Sequencer

This block is a control state machine that moves a dot-clock PLL to a new configuration through a simple register port. The port holds two words: a control word, which carries the lock, reset, bypass and half-pixel flags, and a configuration word, which selects the output frequency. On a request the sequencer reads both words. If the PLL already reports lock and already holds the requested configuration, the sequence ends without touching the PLL.

Otherwise the sequencer writes the new configuration with reset raised, bypass dropped and half-pixel dropped. It then waits a settling time counted in clock cycles, polls the lock flag up to a fixed number of times, and finally writes the control word once more with only the reset flag lowered. The final write is made whether or not lock was seen. If every poll misses lock, a timeout flag is raised. That flag stays up until the next request is accepted.

A requester sees a busy level and a one-cycle done pulse. Requests are only taken while the block is idle.

Top module: `dotpll_reseq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy`, `done`, `timeout`, `pll_rd` and `pll_wr` are all 0.
- R2: A request is accepted only when `busy` is 0. Any `req_valid` seen while busy is ignored: the configuration that is written and the timing of the sequence stay those of the request already accepted.
- R3: One cycle after acceptance, `pll_rd` is high for one cycle. Read data (`pll_rd_ctrl`, `pll_rd_cfg`) is taken in the cycle that follows any read strobe.
- R4: If the first read shows the lock flag (control bit 25) set and a configuration equal to the request, no write is made and `done` pulses 3 cycles after acceptance.
- R5: Otherwise, 3 cycles after acceptance, one program write is made. Its configuration is the requested value. Its control word is the value read, with bypass (bit 15) and half-pixel (bit 24) cleared and reset (bit 0) set.
- R6: The first poll read comes CLK_MHZ*SETTLE_US+1 cycles after the program write. No read is made between the two.
- R7: Poll reads are 2 cycles apart. Polling stops after the first read that shows lock, and after at most MAX_POLLS reads.
- R8: A release write follows 2 cycles after the last poll read. It carries the last control word read with bit 0 cleared and all other bits kept, plus the last configuration read.
- R9: `timeout` rises together with the release write when MAX_POLLS reads all miss lock. It holds until the next acceptance clears it. It stays 0 when lock is seen.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `done` is a single-cycle pulse, and the block is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request a reprogram to `req_cfg` |
| req_cfg | input | CFG_W | Requested PLL configuration |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | Last sequence ran out of polls without lock |
| pll_rd | output | 1 | Read strobe to the PLL register port |
| pll_rd_ctrl | input | CTRL_W | Control word returned, valid the cycle after `pll_rd` |
| pll_rd_cfg | input | CFG_W | Configuration returned, valid the cycle after `pll_rd` |
| pll_wr | output | 1 | Write strobe to the PLL register port |
| pll_wr_ctrl | output | CTRL_W | Control word to write |
| pll_wr_cfg | output | CFG_W | Configuration to write |

## Verification
Every result lands at a fixed offset from the acceptance edge A. The first read comes at A+1, and the program write (or `done` on an early exit) at A+3. Poll n comes at A+3+S+1+2(n-1), where S is the settle count. The release write comes 2 cycles after the last poll and `done` 1 cycle after that. The bench works out the lock poll from the modelled lock delay, builds this schedule for each case, and checks every strobe, level and written word on every falling edge from A+1 through two cycles past `done`. Any early, late or missing event therefore shows up in the exact cycle where it goes wrong.

// File: rtl/dotpll_reseq_pkg.sv
package dotpll_reseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_FETCH   = 4'd1,
        ST_JUDGE   = 4'd2,
        ST_PROGRAM = 4'd3,
        ST_SETTLE  = 4'd4,
        ST_POLL    = 4'd5,
        ST_SAMPLE  = 4'd6,
        ST_RELEASE = 4'd7,
        ST_FINISH  = 4'd8
    } seq_state_e;

endpackage

// File: rtl/dotpll_settle_timer.sv
module dotpll_settle_timer #(
    parameter int unsigned CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Load CYCLES-1 on start so that a state polling `expired` stays CYCLES cycles
    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dotpll_poll_counter.sv
module dotpll_poll_counter #(
    parameter int unsigned MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int unsigned CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step && !last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // High once the poll budget has been spent
    assign last = (cnt_q == CW'(MAX_POLLS));

endmodule

// File: rtl/dotpll_ctrl_edit.sv
module dotpll_ctrl_edit #(
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned RST_BIT  = 0,
    parameter int unsigned BYP_BIT  = 15,
    parameter int unsigned HALF_BIT = 24
) (
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [CTRL_W-1:0] prog_word,
    output logic [CTRL_W-1:0] release_word
);
    localparam logic [CTRL_W-1:0] RST_M  = CTRL_W'(1) << RST_BIT;
    localparam logic [CTRL_W-1:0] CLR_M  = (CTRL_W'(1) << BYP_BIT) | (CTRL_W'(1) << HALF_BIT);

    // Program: drop bypass and half-pixel, raise reset; release: drop reset only
    assign prog_word    = (ctrl_in & ~CLR_M) | RST_M;
    assign release_word = ctrl_in & ~RST_M;

endmodule

// File: rtl/dotpll_reseq.sv
module dotpll_reseq
    import dotpll_reseq_pkg::*;
#(
    parameter int unsigned CTRL_W    = 32,
    parameter int unsigned CFG_W     = 32,
    parameter int unsigned CLK_MHZ   = 125,
    parameter int unsigned SETTLE_US = 100,
    parameter int unsigned MAX_POLLS = 1000,
    parameter int unsigned LOCK_BIT  = 25,
    parameter int unsigned RST_BIT   = 0,
    parameter int unsigned BYP_BIT   = 15,
    parameter int unsigned HALF_BIT  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CFG_W-1:0]  req_cfg,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic              pll_rd,
    input  logic [CTRL_W-1:0] pll_rd_ctrl,
    input  logic [CFG_W-1:0]  pll_rd_cfg,
    output logic              pll_wr,
    output logic [CTRL_W-1:0] pll_wr_ctrl,
    output logic [CFG_W-1:0]  pll_wr_cfg
);
    localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;

    typedef struct packed {
        seq_state_e        state;
        logic [CFG_W-1:0]  target;
        logic [CTRL_W-1:0] ctrl;
        logic [CFG_W-1:0]  cfg;
        logic              timeout;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              settle_start, settle_expired;
    logic              poll_clear, poll_step, poll_last;
    logic              lock_seen, cfg_match;
    logic [CTRL_W-1:0] prog_word, release_word;

    assign lock_seen = pll_rd_ctrl[LOCK_BIT];
    assign cfg_match = (pll_rd_cfg == r_q.target);

    dotpll_settle_timer #(
        .CYCLES (SETTLE_CYC)
    ) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (settle_start),
        .expired (settle_expired)
    );

    dotpll_poll_counter #(
        .MAX_POLLS (MAX_POLLS)
    ) u_polls (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .step  (poll_step),
        .last  (poll_last)
    );

    dotpll_ctrl_edit #(
        .CTRL_W   (CTRL_W),
        .RST_BIT  (RST_BIT),
        .BYP_BIT  (BYP_BIT),
        .HALF_BIT (HALF_BIT)
    ) u_edit (
        .ctrl_in      (r_q.ctrl),
        .prog_word    (prog_word),
        .release_word (release_word)
    );

    always_comb begin
        r_d          = r_q;
        settle_start = 1'b0;
        poll_clear   = 1'b0;
        poll_step    = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.target  = req_cfg;
                    r_d.timeout = 1'b0;
                    r_d.state   = ST_FETCH;
                end
            end
            ST_FETCH: r_d.state = ST_JUDGE;
            ST_JUDGE: begin
                r_d.ctrl = pll_rd_ctrl;
                r_d.cfg  = pll_rd_cfg;
                if (lock_seen && cfg_match) r_d.state = ST_FINISH;
                else                        r_d.state = ST_PROGRAM;
            end
            ST_PROGRAM: begin
                settle_start = 1'b1;
                poll_clear   = 1'b1;
                r_d.state    = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_expired) r_d.state = ST_POLL;
            end
            ST_POLL: begin
                poll_step = 1'b1;
                r_d.state = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                r_d.ctrl = pll_rd_ctrl;
                r_d.cfg  = pll_rd_cfg;
                if (lock_seen) begin
                    r_d.state = ST_RELEASE;
                end else if (poll_last) begin
                    r_d.timeout = 1'b1;
                    r_d.state   = ST_RELEASE;
                end else begin
                    r_d.state = ST_POLL;
                end
            end
            ST_RELEASE: r_d.state = ST_FINISH;
            ST_FINISH:  r_d.state = ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy        = (r_q.state != ST_IDLE);
    assign done        = (r_q.state == ST_FINISH);
    assign timeout     = r_q.timeout;
    assign pll_rd      = (r_q.state == ST_FETCH) || (r_q.state == ST_POLL);
    assign pll_wr      = (r_q.state == ST_PROGRAM) || (r_q.state == ST_RELEASE);
    assign pll_wr_ctrl = (r_q.state == ST_PROGRAM) ? prog_word : release_word;
    assign pll_wr_cfg  = (r_q.state == ST_PROGRAM) ? r_q.target : r_q.cfg;

endmodule

// File: rtl/dotpll_reseq_chk.sv
module dotpll_reseq_chk #(
    parameter int unsigned CTRL_W     = 32,
    parameter int unsigned SETTLE_CYC = 12500,
    parameter int unsigned RST_BIT    = 0,
    parameter int unsigned BYP_BIT    = 15,
    parameter int unsigned HALF_BIT   = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              timeout,
    input logic              pll_rd,
    input logic              pll_wr,
    input logic [CTRL_W-1:0] pll_wr_ctrl
);
    localparam int unsigned SW = $clog2(SETTLE_CYC + 2);

    logic [SW-1:0] since_q;
    logic          armed_q;

    // Cycles since the last write with reset raised, saturating at the settle count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            armed_q <= 1'b0;
        end else if (pll_wr && pll_wr_ctrl[RST_BIT]) begin
            since_q <= '0;
            armed_q <= 1'b1;
        end else if (since_q < SW'(SETTLE_CYC)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R2
    accept_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R5
    prog_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_wr && pll_wr_ctrl[RST_BIT]) |-> (!pll_wr_ctrl[BYP_BIT] && !pll_wr_ctrl[HALF_BIT]));

    // R6
    settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rd |-> (!armed_q || since_q >= SW'(SETTLE_CYC)));

    // R7
    poll_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rd |=> (!pll_rd && !pll_wr));

    // R8
    release_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_wr && !pll_wr_ctrl[RST_BIT]) |=> done);

    // R9
    timeout_with_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (pll_wr && !pll_wr_ctrl[RST_BIT]));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_rd || pll_wr) |-> busy);

endmodule

bind dotpll_reseq dotpll_reseq_chk #(
    .CTRL_W     (CTRL_W),
    .SETTLE_CYC (CLK_MHZ * SETTLE_US),
    .RST_BIT    (RST_BIT),
    .BYP_BIT    (BYP_BIT),
    .HALF_BIT   (HALF_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .timeout     (timeout),
    .pll_rd      (pll_rd),
    .pll_wr      (pll_wr),
    .pll_wr_ctrl (pll_wr_ctrl)
);

// File: tb/dotpll_reseq_bench.sv
`timescale 1ns/1ps
module dotpll_reseq_bench;
    localparam int S         = 125 * 100;
    localparam int MAXP      = 1000;
    localparam logic [31:0] LOCK_M = 32'h0200_0000;
    localparam logic [31:0] RST_M  = 32'h0000_0001;
    localparam logic [31:0] BYP_M  = 32'h0000_8000;
    localparam logic [31:0] HALF_M = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_cfg = '0;
    logic        busy, done, timeout, pll_rd, pll_wr;
    logic [31:0] rd_ctrl = '0, rd_cfg = '0, pll_wr_ctrl, pll_wr_cfg;

    always #4 clk = ~clk;

    dotpll_reseq u_dotpll_reseq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cfg(req_cfg),
        .busy(busy), .done(done), .timeout(timeout),
        .pll_rd(pll_rd), .pll_rd_ctrl(rd_ctrl), .pll_rd_cfg(rd_cfg),
        .pll_wr(pll_wr), .pll_wr_ctrl(pll_wr_ctrl), .pll_wr_cfg(pll_wr_cfg)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // PLL register model: lock rises a programmable number of cycles after a reset write
    logic [31:0] m_ctrl = '0, m_cfg = '0, p_ctrl = '0, p_cfg = '0;
    int          m_age = 0, m_delay = -1, p_age = 0, p_delay = -1;
    logic        preset = 1'b0;
    logic        m_lock;
    assign m_lock = (m_delay >= 0) && (m_age >= m_delay);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (preset) begin
            m_ctrl <= p_ctrl; m_cfg <= p_cfg; m_age <= p_age; m_delay <= p_delay;
        end else begin
            if (pll_rd) begin
                rd_ctrl <= (m_ctrl & ~LOCK_M) | (m_lock ? LOCK_M : 32'h0);
                rd_cfg  <= m_cfg;
            end
            if (pll_wr) begin
                m_ctrl <= pll_wr_ctrl & ~LOCK_M;
                m_cfg  <= pll_wr_cfg;
            end
            if (pll_wr && pll_wr_ctrl[0]) m_age <= 0;
            else if (m_age < 1000000)     m_age <= m_age + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 195000) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog: actual busy=%0b expected sequence end", busy);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_case(input logic [31:0] ic, input logic [31:0] icfg, input bit ilock,
                            input logic [31:0] rq, input int d, input bit intrude);
        int n, rel, dn;
        bit locked, early, e_rd, e_wr, e_busy, e_done, e_to;
        logic [31:0] ir, pe, re;
        string t_rd, t_wr, t_dn;
        @(negedge clk);
        p_ctrl = ic & ~LOCK_M; p_cfg = icfg; p_age = ilock ? 1000000 : 0; p_delay = d;
        preset = 1'b1;
        @(negedge clk);
        preset = 1'b0;
        ir    = (ic & ~LOCK_M) | (ilock ? LOCK_M : 32'h0);
        early = ilock && (icfg == rq);
        if (d < 0) begin n = MAXP; locked = 0; end
        else begin
            n = (d <= S) ? 1 : ((d - S + 1) / 2) + 1;
            if (n > MAXP) begin n = MAXP; locked = 0; end else locked = 1;
        end
        pe  = (ir & ~BYP_M & ~HALF_M) | RST_M;
        re  = (pe & ~LOCK_M & ~RST_M) | (locked ? LOCK_M : 32'h0);
        rel = 3 + S + 2 * n + 1;
        dn  = early ? 3 : rel + 1;
        req_valid = 1'b1; req_cfg = rq;
        for (int off = 1; off <= dn + 2; off++) begin
            @(negedge clk);
            req_valid = intrude && off >= 6 && off <= 8;
            req_cfg   = rq ^ 32'h0000_FFFF;
            e_rd   = (off == 1) || (!early && off >= S + 4 && off <= S + 4 + 2 * (n - 1)
                                    && ((off - (S + 4)) % 2 == 0));
            e_wr   = !early && (off == 3 || off == rel);
            e_busy = (off <= dn);
            e_done = (off == dn);
            e_to   = !early && !locked && off >= rel;
            t_rd = (off == 1) ? "R3" : (off < S + 4) ? "R6" : "R7";
            t_wr = early ? "R4" : (off <= 3) ? "R5" : "R8";
            t_dn = early ? "R4" : "R10";
            chk(pll_rd == e_rd, t_rd, 32'(pll_rd), 32'(e_rd));
            chk(pll_wr == e_wr, t_wr, 32'(pll_wr), 32'(e_wr));
            chk(busy == e_busy, intrude ? "R2" : "R10", 32'(busy), 32'(e_busy));
            chk(done == e_done, t_dn, 32'(done), 32'(e_done));
            chk(timeout == e_to, "R9", 32'(timeout), 32'(e_to));
            if (e_wr && pll_wr) begin
                if (off == 3) begin
                    chk(pll_wr_ctrl == pe, "R5", pll_wr_ctrl, pe);
                    chk(pll_wr_cfg == rq, intrude ? "R2" : "R5", pll_wr_cfg, rq);
                end else begin
                    chk(pll_wr_ctrl == re, "R8", pll_wr_ctrl, re);
                    chk(pll_wr_cfg == rq, intrude ? "R2" : "R8", pll_wr_cfg, rq);
                end
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!busy && !done && !timeout && !pll_rd && !pll_wr, "R1",
            {27'h0, busy, done, timeout, pll_rd, pll_wr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !timeout && !pll_rd && !pll_wr, "R1",
            {27'h0, busy, done, timeout, pll_rd, pll_wr}, 32'h0);
        // R4: locked at the requested value, early exit
        run_case(32'h0100_8A5C, 32'h0000_215D, 1'b1, 32'h0000_215D, 0, 1'b0);
        // R5 R8: locked at another value, lock on the first poll
        run_case(32'h0100_8A5C, 32'h0000_1087, 1'b1, 32'h0000_215D, 10, 1'b0);
        // R7 R2: unlocked, lock on the fourth poll, intruding request while busy
        run_case(32'h0000_8004, 32'h0000_4249, 1'b0, 32'h0000_4249, S + 5, 1'b1);
        // R9: never locks, all polls spent
        run_case(32'h0100_0000, 32'h0000_0057, 1'b0, 32'h0000_31E4, -1, 1'b0);
        // R9: next acceptance clears timeout (early exit)
        run_case(32'h0000_0000, 32'h0000_6363, 1'b1, 32'h0000_6363, 0, 1'b0);
        // R7 R9: lock seen exactly on the last allowed poll
        run_case(32'h0000_8000, 32'h0000_2130, 1'b0, 32'h0000_0041, S + 2 * (MAXP - 1), 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule